// File: doc/BRIEF.md
# Address-Space-Tagged Indirect Branch Target Predictor

This block remembers where indirect branches went the last time they resolved and offers that destination as a guess when fetch reaches the same branch again. It is a direct-mapped table: the low-order bits of a branch's virtual address pick one entry, and the entry keeps a valid flag, the rest of the address as a tag, an address-space identifier (ASID) and the target. Resolved branches write the table through an update port. Fetch reads it through a lookup port, and the answer appears on registered outputs one cycle later.

A lookup hits only when the entry is valid, its tag matches every address bit above the index, and its stored ASID equals the current one. A branch in one process or in the kernel that shares the index bits with a branch somewhere else therefore cannot steer that other branch's prediction. A control input turns every prediction off while it is set. This is meant for the period after a move into a privileged mode. A build option also blocks prediction for any lookup made in privileged mode. An invalidate strobe empties the whole table in a single cycle.

Top module: `ibtb`

## Requirements
- R1: After reset, `pred_vld_o` and `pred_tgt_o` are 0 and every entry is invalid. A reset in the middle of operation also discards all entries.
- R2: With the default 64 entries, bits [5:0] of the virtual address form the index and bits [31:6] form the tag. After an update, a lookup with the same address and ASID returns `pred_vld_o`=1 and the written target. This holds for index 0, for index 63 and for every index in between.
- R3: The result of a lookup is registered. It appears on the outputs in the cycle after `lk_vld_i` is sampled. A cycle without a lookup gives `pred_vld_o`=0 in the next cycle.
- R4: A lookup whose index matches an entry but whose address differs in any tag bit is a miss. This includes a difference only in bit 31.
- R5: A lookup whose ASID differs from the ASID stored in the entry is a miss.
- R6: An update always overwrites the indexed entry with a new tag, ASID and target. The previous contents of that entry can no longer be hit.
- R7: While `ind_off_i`=1, no lookup produces a prediction. Table contents are kept, so the same lookup hits again once `ind_off_i` returns to 0.
- R8: With `STOP_IN_PRIV`=1 (the default), a lookup made with `lk_priv_i`=1 produces no prediction.
- R9: `inval_all_i` clears every entry in one cycle. A lookup made in that cycle misses. An update made in that same cycle is dropped.
- R10: Whenever `pred_vld_o`=0, `pred_tgt_o` is 0.
- R11: When an update and a lookup hit the same entry in the same cycle, the lookup sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_vld_i | input | 1 | Lookup request this cycle |
| lk_va_i | input | VA_W | Fetch virtual address to look up |
| lk_asid_i | input | ASID_W | Current address-space identifier |
| lk_priv_i | input | 1 | Lookup made in privileged mode |
| upd_vld_i | input | 1 | Resolved indirect branch to record |
| upd_va_i | input | VA_W | Address of the resolved branch |
| upd_asid_i | input | ASID_W | ASID of the resolved branch |
| upd_tgt_i | input | TGT_W | Actual target of the resolved branch |
| inval_all_i | input | 1 | Clear every entry |
| ind_off_i | input | 1 | Suppress all indirect predictions |
| pred_vld_o | output | 1 | Registered prediction available |
| pred_tgt_o | output | TGT_W | Registered predicted target, 0 when none |

## Verification
The assertions assume that inputs are stable and known at each rising clock edge. They also assume that `inval_all_i` is a pulse the surrounding logic may raise in any cycle, including cycles that carry a lookup or an update. The stimulus keeps to this by changing inputs only on the falling edge and by holding all strobes low outside the vectors that use them. The property on the cycle after an invalidate also assumes that no update lands in between. The stimulus follows every invalidate with lookups alone, and it writes the table again only after those lookups.

// File: rtl/ibtb_pkg.sv
package ibtb_pkg;

   // Outcome of one lookup as seen by the match stage
   typedef enum logic [1:0] {
      LK_IDLE    = 2'd0,
      LK_MISS    = 2'd1,
      LK_HIT     = 2'd2,
      LK_BLOCKED = 2'd3
   } lk_res_e;

   localparam int unsigned DEF_VA_W   = 32;
   localparam int unsigned DEF_TGT_W  = 32;
   localparam int unsigned DEF_ASID_W = 8;
   localparam int unsigned DEF_DEPTH  = 64;

endpackage

// File: rtl/ibtb_store.sv
module ibtb_store #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned IDX_W  = 6,
   parameter int unsigned TAG_W  = 26,
   parameter int unsigned ASID_W = 8,
   parameter int unsigned TGT_W  = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_idx_i,
   input  logic [TAG_W-1:0]  wr_tag_i,
   input  logic [ASID_W-1:0] wr_asid_i,
   input  logic [TGT_W-1:0]  wr_tgt_i,
   input  logic              clr_all_i,
   input  logic [IDX_W-1:0]  rd_idx_i,
   output logic              rd_vld_o,
   output logic [TAG_W-1:0]  rd_tag_o,
   output logic [ASID_W-1:0] rd_asid_o,
   output logic [TGT_W-1:0]  rd_tgt_o
);

   logic [DEPTH-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q  [DEPTH];
   logic [ASID_W-1:0] asid_q [DEPTH];
   logic [TGT_W-1:0]  tgt_q  [DEPTH];

   // Invalidate outranks a write in the same cycle
   logic wr_ok;
   assign wr_ok = wr_en_i & ~clr_all_i;

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic sel;
      assign sel = wr_ok && (wr_idx_i == IDX_W'(e));

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vld_q[e] <= 1'b0;
         end else if (clr_all_i) begin
            vld_q[e] <= 1'b0;
         end else if (sel) begin
            vld_q[e] <= 1'b1;
         end
      end

      always_ff @(posedge clk_i) begin
         if (sel) begin
            tag_q[e]  <= wr_tag_i;
            asid_q[e] <= wr_asid_i;
            tgt_q[e]  <= wr_tgt_i;
         end
      end
   end

   // Read sees contents from before this edge's write
   assign rd_vld_o  = vld_q[rd_idx_i];
   assign rd_tag_o  = tag_q[rd_idx_i];
   assign rd_asid_o = asid_q[rd_idx_i];
   assign rd_tgt_o  = tgt_q[rd_idx_i];

endmodule

// File: rtl/ibtb_match.sv
module ibtb_match
   import ibtb_pkg::*;
#(
   parameter int unsigned TAG_W  = 26,
   parameter int unsigned ASID_W = 8
) (
   input  logic              lk_vld_i,
   input  logic              blocked_i,
   input  logic              clr_all_i,
   input  logic [TAG_W-1:0]  lk_tag_i,
   input  logic [ASID_W-1:0] lk_asid_i,
   input  logic              ent_vld_i,
   input  logic [TAG_W-1:0]  ent_tag_i,
   input  logic [ASID_W-1:0] ent_asid_i,
   output lk_res_e           res_o
);

   logic same_tag, same_asid;
   assign same_tag  = (lk_tag_i == ent_tag_i);
   assign same_asid = (lk_asid_i == ent_asid_i);

   always_comb begin
      if (!lk_vld_i) begin
         res_o = LK_IDLE;
      end else if (blocked_i || clr_all_i) begin
         res_o = LK_BLOCKED;
      end else if (ent_vld_i && same_tag && same_asid) begin
         res_o = LK_HIT;
      end else begin
         res_o = LK_MISS;
      end
   end

endmodule

// File: rtl/ibtb.sv
module ibtb
   import ibtb_pkg::*;
#(
   parameter int unsigned VA_W         = DEF_VA_W,
   parameter int unsigned TGT_W        = DEF_TGT_W,
   parameter int unsigned ASID_W       = DEF_ASID_W,
   parameter int unsigned DEPTH        = DEF_DEPTH,
   parameter bit          STOP_IN_PRIV = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              lk_vld_i,
   input  logic [VA_W-1:0]   lk_va_i,
   input  logic [ASID_W-1:0] lk_asid_i,
   input  logic              lk_priv_i,
   input  logic              upd_vld_i,
   input  logic [VA_W-1:0]   upd_va_i,
   input  logic [ASID_W-1:0] upd_asid_i,
   input  logic [TGT_W-1:0]  upd_tgt_i,
   input  logic              inval_all_i,
   input  logic              ind_off_i,
   output logic              pred_vld_o,
   output logic [TGT_W-1:0]  pred_tgt_o
);

   localparam int unsigned IDX_W = $clog2(DEPTH);
   localparam int unsigned TAG_W = VA_W - IDX_W;

   // Elaboration checks on the parameter set
   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("ibtb: DEPTH must be a power of two of at least 2");
   end
   if (VA_W <= IDX_W) begin : g_bad_va
      $error("ibtb: VA_W must exceed the index width");
   end
   if (ASID_W < 1 || TGT_W < 1) begin : g_bad_w
      $error("ibtb: ASID_W and TGT_W must be positive");
   end

   // Prediction gating variant
   logic blocked;
   if (STOP_IN_PRIV) begin : g_gate_priv
      assign blocked = ind_off_i | lk_priv_i;
   end else begin : g_gate_ctl
      logic unused_priv;
      assign unused_priv = lk_priv_i;
      assign blocked     = ind_off_i;
   end

   logic              ent_vld;
   logic [TAG_W-1:0]  ent_tag;
   logic [ASID_W-1:0] ent_asid;
   logic [TGT_W-1:0]  ent_tgt;
   lk_res_e           res;

   ibtb_store #(
      .DEPTH (DEPTH),
      .IDX_W (IDX_W),
      .TAG_W (TAG_W),
      .ASID_W(ASID_W),
      .TGT_W (TGT_W)
   ) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_en_i  (upd_vld_i),
      .wr_idx_i (upd_va_i[IDX_W-1:0]),
      .wr_tag_i (upd_va_i[VA_W-1:IDX_W]),
      .wr_asid_i(upd_asid_i),
      .wr_tgt_i (upd_tgt_i),
      .clr_all_i(inval_all_i),
      .rd_idx_i (lk_va_i[IDX_W-1:0]),
      .rd_vld_o (ent_vld),
      .rd_tag_o (ent_tag),
      .rd_asid_o(ent_asid),
      .rd_tgt_o (ent_tgt)
   );

   ibtb_match #(
      .TAG_W (TAG_W),
      .ASID_W(ASID_W)
   ) u_match (
      .lk_vld_i  (lk_vld_i),
      .blocked_i (blocked),
      .clr_all_i (inval_all_i),
      .lk_tag_i  (lk_va_i[VA_W-1:IDX_W]),
      .lk_asid_i (lk_asid_i),
      .ent_vld_i (ent_vld),
      .ent_tag_i (ent_tag),
      .ent_asid_i(ent_asid),
      .res_o     (res)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pred_vld_o <= 1'b0;
         pred_tgt_o <= '0;
      end else if (res == LK_HIT) begin
         pred_vld_o <= 1'b1;
         pred_tgt_o <= ent_tgt;
      end else begin
         pred_vld_o <= 1'b0;
         pred_tgt_o <= '0;
      end
   end

endmodule

// File: rtl/ibtb_chk.sv
module ibtb_chk #(
   parameter int unsigned TGT_W        = 32,
   parameter bit          STOP_IN_PRIV = 1'b1
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             lk_vld_i,
   input logic             lk_priv_i,
   input logic             upd_vld_i,
   input logic             inval_all_i,
   input logic             ind_off_i,
   input logic             pred_vld_o,
   input logic [TGT_W-1:0] pred_tgt_o
);

   // R10: a silent output carries a zero target
   a_r10_tgt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !pred_vld_o |-> pred_tgt_o == '0);

   // R3: no lookup, no prediction in the next cycle
   a_r3_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lk_vld_i |=> !pred_vld_o);

   // R7: control bit suppresses prediction
   a_r7_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ind_off_i |=> !pred_vld_o);

   // R9: lookup in the invalidate cycle misses
   a_r9_inval_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inval_all_i |=> !pred_vld_o);

   // R9: first lookup after invalidate, with no update between, misses
   a_r9_inval_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
      inval_all_i ##1 (lk_vld_i && !upd_vld_i) |=> !pred_vld_o);

   if (STOP_IN_PRIV) begin : g_priv
      // R8: privileged lookups stay unpredicted
      a_r8_priv_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
         lk_priv_i |=> !pred_vld_o);
   end

endmodule

bind ibtb ibtb_chk #(
   .TGT_W       (TGT_W),
   .STOP_IN_PRIV(STOP_IN_PRIV)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .lk_vld_i   (lk_vld_i),
   .lk_priv_i  (lk_priv_i),
   .upd_vld_i  (upd_vld_i),
   .inval_all_i(inval_all_i),
   .ind_off_i  (ind_off_i),
   .pred_vld_o (pred_vld_o),
   .pred_tgt_o (pred_tgt_o)
);

// File: tb/ibtb_bench.sv
module ibtb_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 20;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_vld = 1'b0;
   logic [31:0] lk_va = '0;
   logic [7:0]  lk_asid = '0;
   logic        lk_priv = 1'b0;
   logic        upd_vld = 1'b0;
   logic [31:0] upd_va = '0;
   logic [7:0]  upd_asid = '0;
   logic [31:0] upd_tgt = '0;
   logic        inval = 1'b0;
   logic        off = 1'b0;
   logic        pv;
   logic [31:0] pt;

   int n_run  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ibtb u_ibtb (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .lk_vld_i   (lk_vld),
      .lk_va_i    (lk_va),
      .lk_asid_i  (lk_asid),
      .lk_priv_i  (lk_priv),
      .upd_vld_i  (upd_vld),
      .upd_va_i   (upd_va),
      .upd_asid_i (upd_asid),
      .upd_tgt_i  (upd_tgt),
      .inval_all_i(inval),
      .ind_off_i  (off),
      .pred_vld_o (pv),
      .pred_tgt_o (pt)
   );

   typedef struct packed {
      logic        u;
      logic [31:0] ua;
      logic [7:0]  uas;
      logic [31:0] ut;
      logic        l;
      logic [31:0] la;
      logic [7:0]  las;
      logic        pr;
      logic        of;
      logic        iv;
      logic        epv;
      logic [31:0] et;
      logic [7:0]  req;
   } vec_t;

   localparam logic [31:0] A = 32'h0000_1004;
   localparam logic [31:0] B = 32'h0000_103F;
   localparam logic [31:0] C = 32'h0000_0010;

   localparam vec_t VT [NVEC] = '{
      // u  ua  uas    ut             l  la             las    pr  of  iv  epv et             req
      '{1'b1, A, 8'd3, 32'h8000_0100, 1'b0, 32'h0, 8'd0, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd3},          // R3
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, A, 8'd3, 1'b0,1'b0,1'b0, 1'b1, 32'h8000_0100, 8'd2},          // R2
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, 32'h0000_2004, 8'd3, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd4},      // R4
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, 32'h8000_1004, 8'd3, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd4},      // R4
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, A, 8'd5, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd5},                  // R5
      '{1'b1, B, 8'd5, 32'h9000_0000, 1'b1, A, 8'd3, 1'b0,1'b0,1'b0, 1'b1, 32'h8000_0100, 8'd2},      // R2
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, B, 8'd5, 1'b0,1'b0,1'b0, 1'b1, 32'h9000_0000, 8'd2},          // R2
      '{1'b1, A, 8'd7, 32'h8000_0200, 1'b1, A, 8'd3, 1'b0,1'b0,1'b0, 1'b1, 32'h8000_0100, 8'd11},     // R11
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, A, 8'd3, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd6},                  // R6
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, A, 8'd7, 1'b0,1'b0,1'b0, 1'b1, 32'h8000_0200, 8'd6},          // R6
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, A, 8'd7, 1'b0,1'b1,1'b0, 1'b0, 32'h0, 8'd7},                  // R7
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, A, 8'd7, 1'b0,1'b0,1'b0, 1'b1, 32'h8000_0200, 8'd7},          // R7
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, A, 8'd7, 1'b1,1'b0,1'b0, 1'b0, 32'h0, 8'd8},                  // R8
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b0, A, 8'd7, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd3},                  // R3
      '{1'b1, C, 8'd1, 32'h1234_5678, 1'b1, A, 8'd7, 1'b0,1'b0,1'b1, 1'b0, 32'h0, 8'd9},              // R9
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, A, 8'd7, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd9},                  // R9
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, B, 8'd5, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd9},                  // R9
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, C, 8'd1, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd9},                  // R9
      '{1'b1, C, 8'd1, 32'h1234_5678, 1'b0, 32'h0, 8'd0, 1'b0,1'b0,1'b0, 1'b0, 32'h0, 8'd10},         // R10
      '{1'b0, 32'h0, 8'd0, 32'h0, 1'b1, C, 8'd1, 1'b0,1'b0,1'b0, 1'b1, 32'h1234_5678, 8'd2}           // R2
   };

   task automatic check(input string req, input logic epv, input logic [31:0] et);
      n_run++;
      if (pv !== epv || pt !== et) begin
         n_fail++;
         $display("FAIL %s: got vld=%0b tgt=%h, expected vld=%0b tgt=%h", req, pv, pt, epv, et);
      end
   endtask

   task automatic idle();
      upd_vld = 1'b0; lk_vld = 1'b0; lk_priv = 1'b0; off = 1'b0; inval = 1'b0;
   endtask

   // Called at a falling edge: present inputs, pass one rising edge, return at the next falling edge
   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * WATCHDOG);
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      @(negedge clk);
      check("R1 reset outputs", 1'b0, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 1'b0, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         upd_vld = VT[i].u;  upd_va = VT[i].ua; upd_asid = VT[i].uas; upd_tgt = VT[i].ut;
         lk_vld = VT[i].l;   lk_va = VT[i].la;  lk_asid = VT[i].las;  lk_priv = VT[i].pr;
         off = VT[i].of;     inval = VT[i].iv;
         step();
         check($sformatf("R%0d vector %0d", VT[i].req, i), VT[i].epv, VT[i].et);
      end
      idle();

      // R2: every index from 0 to 63 holds its own target
      for (int k = 0; k < 64; k++) begin
         upd_vld = 1'b1; upd_va = {26'(k + 100), 6'(k)}; upd_asid = 8'(k); upd_tgt = 32'hA000_0000 + 32'(k);
         step();
      end
      idle();
      for (int k = 0; k < 64; k++) begin
         lk_vld = 1'b1; lk_va = {26'(k + 100), 6'(k)}; lk_asid = 8'(k);
         step();
         check($sformatf("R2 index %0d", k), 1'b1, 32'hA000_0000 + 32'(k));
      end
      idle();

      // R1: reset in mid-run discards entries
      rst_n = 1'b0;
      step();
      check("R1 mid reset outputs", 1'b0, 32'h0);
      rst_n = 1'b1;
      step();
      lk_vld = 1'b1; lk_va = {26'd163, 6'd63}; lk_asid = 8'd63;
      step();
      check("R1 entry cleared by reset", 1'b0, 32'h0);
      idle();
      step();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule